// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic-logic unit that sits beside an accumulator. It combines the accumulator with a second operand, taken from a register or from memory, under a 4-bit operation code and an external carry input. The 8-bit result is meant to be written back in place of the accumulator. Both the result and a packed flag byte are produced combinationally in the same cycle as the inputs.

The flag byte holds five status bits: sign, zero, auxiliary carry, even parity and carry. On subtraction the carry bit acts as a borrow. A flag register captures the flag byte on any clock edge where the load enable is high. The register-file selection and the instruction decoding live outside the block.

Top module: `acc_alu`

## Requirements
- R1: Codes 0 (AND), 1 (OR) and 2 (XOR) give the bitwise function of acc_i and opnd_i. Code 5 gives the complement of acc_i. All four clear both the carry and the auxiliary carry.
- R2: Code 4'd3 (add) gives (acc_i + opnd_i + carry_i) mod 256. Carry is set when the sum exceeds 255. Auxiliary carry is set when the low nibbles plus carry_i exceed 15.
- R3: Code 4'd4 (subtract) gives (acc_i - opnd_i - carry_i) mod 256. Carry is set as a borrow when the true difference is negative. Auxiliary carry is set when the low-nibble difference is negative.
- R4: Code 6 (increment) and code 7 (decrement) add or subtract one from acc_i, and the carry output equals carry_i. Auxiliary carry is set on increment when acc_i[3:0] is 4'hF, and on decrement when acc_i[3:0] is 0.
- R5: Code 8 (shift left) and code 9 (shift right) fill the vacated bit with 0. The outgoing bit (bit 7 on a left shift, bit 0 on a right shift) goes to carry. Auxiliary carry is cleared.
- R6: The sign flag equals result bit 7. The zero flag is set exactly when the 8-bit result is zero.
- R7: The parity flag is set when the result holds an even number of ones.
- R8: The flag byte is {S, Z, 0, AC, 0, P, 1, CY}, from bit 7 down to bit 0.
- R9: flags_q_o resets to 8'h02. It loads flags_next_o on a rising clock edge where flag_we_i is high, and holds its value otherwise.
- R10: Codes 10 to 15 pass acc_i to the result unchanged, and flags_next_o equals flags_q_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry / borrow input |
| flag_we_i | input | 1 | Flag register load enable |
| result_o | output | 8 | Result to write back to the accumulator |
| flags_next_o | output | 8 | Packed flag byte for the current operation |
| flags_q_o | output | 8 | Registered flag byte |

## Verification
Directed vectors aim at each flag's edge:
- 0x0F+0x01 sets only the auxiliary carry.
- 0xFF+0x01 produces a zero result together with a carry.
- 0x00-0x01 borrows through every bit.
- Increment of 0xFF and decrement of 0x00 wrap while leaving carry at carry_i.
- Shifts of 0x80 and 0x01 push their single set bit into carry.

After the directed vectors, several hundred random operands, codes (including the unused ones), carry inputs and load enables are compared every cycle against a behavioural integer model. These separate a parity error from a zero-flag error, and a held flag register from a loaded one.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_OR  = 4'd1,
    OP_XOR = 4'd2,
    OP_ADD = 4'd3,
    OP_SUB = 4'd4,
    OP_CPL = 4'd5,
    OP_INC = 4'd6,
    OP_DEC = 4'd7,
    OP_SHL = 4'd8,
    OP_SHR = 4'd9
  } alu_op_e;

  localparam logic [7:0] FLAG_RST = 8'h02;
endpackage

// File: rtl/alu_core.sv
module alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              known_o
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W:0] wide;
  logic [HALF:0]   nib;

  always_comb begin
    wide    = '0;
    nib     = '0;
    res_o   = a_i;
    cy_o    = 1'b0;
    ac_o    = 1'b0;
    known_o = 1'b1;
    case (alu_op_e'(op_i))
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_CPL: res_o = ~a_i;
      OP_ADD: begin
        wide  = {1'b0, a_i} + {1'b0, b_i} + (DATA_W+1)'(cin_i);
        nib   = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]} + (HALF+1)'(cin_i);
        res_o = wide[DATA_W-1:0];
        cy_o  = wide[DATA_W];
        ac_o  = nib[HALF];
      end
      OP_SUB: begin
        wide  = {1'b0, a_i} - {1'b0, b_i} - (DATA_W+1)'(cin_i);
        nib   = {1'b0, a_i[HALF-1:0]} - {1'b0, b_i[HALF-1:0]} - (HALF+1)'(cin_i);
        res_o = wide[DATA_W-1:0];
        cy_o  = wide[DATA_W];
        ac_o  = nib[HALF];
      end
      OP_INC: begin
        res_o = a_i + DATA_W'(1);
        cy_o  = cin_i;
        ac_o  = &a_i[HALF-1:0];
      end
      OP_DEC: begin
        res_o = a_i - DATA_W'(1);
        cy_o  = cin_i;
        ac_o  = ~|a_i[HALF-1:0];
      end
      OP_SHL: begin
        res_o = {a_i[DATA_W-2:0], 1'b0};
        cy_o  = a_i[DATA_W-1];
      end
      OP_SHR: begin
        res_o = {1'b0, a_i[DATA_W-1:1]};
        cy_o  = a_i[0];
      end
      default: known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/flag_gen.sv
module flag_gen #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              cy_i,
  input  logic              ac_i,
  input  logic              known_i,
  input  logic [7:0]        held_i,
  output logic [7:0]        flags_o
);
  logic sgn, zro, par;

  always_comb begin
    sgn = res_i[DATA_W-1];
    zro = ~|res_i;
    par = ~^res_i;
    if (known_i) flags_o = {sgn, zro, 1'b0, ac_i, 1'b0, par, 1'b1, cy_i};
    else         flags_o = held_i;
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import acc_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [7:0] d_i,
  output logic [7:0] q_o
);
  logic [7:0] q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (we_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= FLAG_RST;
    else        q_o <= q_nxt;
  end

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_o));
  // R9
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              carry_i,
  input  logic              flag_we_i,
  output logic [DATA_W-1:0] result_o,
  output logic [7:0]        flags_next_o,
  output logic [7:0]        flags_q_o
);
  logic cy_w, ac_w, known_w;

  alu_core #(.DATA_W(DATA_W)) u_core (
    .op_i(op_i), .a_i(acc_i), .b_i(opnd_i), .cin_i(carry_i),
    .res_o(result_o), .cy_o(cy_w), .ac_o(ac_w), .known_o(known_w)
  );

  flag_gen #(.DATA_W(DATA_W)) u_fgen (
    .res_i(result_o), .cy_i(cy_w), .ac_i(ac_w), .known_i(known_w),
    .held_i(flags_q_o), .flags_o(flags_next_o)
  );

  flag_reg u_freg (
    .clk(clk), .rst_n(rst_n), .we_i(flag_we_i),
    .d_i(flags_next_o), .q_o(flags_q_o)
  );

  // R1
  logic_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i inside {OP_AND, OP_OR, OP_XOR, OP_CPL}) |-> (!flags_next_o[0] && !flags_next_o[4]));
  // R4
  incdec_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i inside {OP_INC, OP_DEC}) |-> (flags_next_o[0] == carry_i));
  // R7
  parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i <= 4'd9) |-> (flags_next_o[2] == ($countones(result_o) % 2 == 0)));
  // R8
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q_o[1] && !flags_q_o[3] && !flags_q_o[5]));
  // R10
  unused_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > 4'd9) |-> (result_o == acc_i && flags_next_o == flags_q_o));
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] acc, opnd;
  logic       cin, we;
  logic [7:0] res, fnext, fq;
  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q;

  always #2 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_i(op), .acc_i(acc), .opnd_i(opnd),
    .carry_i(cin), .flag_we_i(we), .result_o(res),
    .flags_next_o(fnext), .flags_q_o(fq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(int o, int a, int b, int c, logic [7:0] held);
    int r = a;
    int cy = 0;
    int ac = 0;
    int ones = 0;
    case (o)
      0: r = a & b;
      1: r = a | b;
      2: r = a ^ b;
      3: begin r = a + b + c; cy = (r > 255); ac = ((a % 16) + (b % 16) + c) > 15; end
      4: begin r = a - b - c; cy = (r < 0); ac = ((a % 16) - (b % 16) - c) < 0; end
      5: r = 255 - a;
      6: begin r = a + 1; cy = c; ac = (a % 16) == 15; end
      7: begin r = a - 1; cy = c; ac = (a % 16) == 0; end
      8: begin r = a * 2; cy = a / 128; end
      9: begin r = a / 2; cy = a % 2; end
      default: return {8'(a), held};
    endcase
    r = r & 255;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    return {8'(r), (r >= 128) ? 1'b1 : 1'b0, (r == 0) ? 1'b1 : 1'b0, 1'b0, 1'(ac),
            1'b0, (ones % 2 == 0) ? 1'b1 : 1'b0, 1'b1, 1'(cy)};
  endfunction

  function automatic string tag_of(int o);
    if (o <= 2 || o == 5) return "R1";
    if (o == 3) return "R2";
    if (o == 4) return "R3";
    if (o == 6 || o == 7) return "R4";
    if (o == 8 || o == 9) return "R5";
    return "R10";
  endfunction

  task automatic apply(int o, int a, int b, int c, int w);
    logic [15:0] e;
    @(negedge clk);
    chk("R9 flag register", fq, exp_q);
    op = 4'(o); acc = 8'(a); opnd = 8'(b); cin = 1'(c); we = 1'(w);
    #1;
    e = model(o, a, b, c, exp_q);
    chk({tag_of(o), " result"}, res, e[15:8]);
    chk({tag_of(o), " R6 R7 R8 flags"}, fnext, e[7:0]);
    @(posedge clk);
    if (w != 0) exp_q = e[7:0];
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op = '0; acc = '0; opnd = '0; cin = 1'b0; we = 1'b0;
    exp_q = 8'h02;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset value", fq, 8'h02);
    rst_n = 1'b1;
    apply(0, 8'hF0, 8'h3C, 1, 1);   // R1 AND
    apply(1, 8'h00, 8'h00, 0, 1);   // R1 OR zero result, R6
    apply(2, 8'hAA, 8'h55, 1, 0);   // R1 XOR
    apply(5, 8'h0F, 8'h00, 1, 1);   // R1 complement
    apply(3, 8'h0F, 8'h01, 0, 1);   // R2 aux carry only
    apply(3, 8'hFF, 8'h01, 0, 1);   // R2 carry + zero
    apply(3, 8'h7F, 8'h00, 1, 0);   // R2 carry-in, sign
    apply(4, 8'h00, 8'h01, 0, 1);   // R3 borrow
    apply(4, 8'h80, 8'h01, 0, 1);   // R3 nibble borrow
    apply(4, 8'h05, 8'h04, 1, 1);   // R3 zero via borrow-in
    apply(6, 8'hFF, 8'h00, 0, 1);   // R4 wrap, carry kept 0
    apply(6, 8'h0F, 8'h00, 1, 1);   // R4 aux, carry kept 1
    apply(7, 8'h00, 8'h00, 1, 1);   // R4 wrap down
    apply(8, 8'h80, 8'h00, 0, 1);   // R5 left out bit
    apply(9, 8'h01, 8'h00, 0, 1);   // R5 right out bit
    apply(12, 8'h5A, 8'h33, 1, 1);  // R10 unused code
    apply(15, 8'hC3, 8'h11, 0, 0);  // R10 unused code
    for (int n = 0; n < 600; n++)
      apply($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
            $urandom_range(0, 1), $urandom_range(0, 1));
    @(negedge clk);
    chk("R9 final flag register", fq, exp_q);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule